// File: doc/BRIEF.md
# Banked Indirect Register Access Unit

This block sits on the target side of a PHY management register file. A small synchronous register bus reaches thirty-two directly addressed 16-bit registers. Three of them form a gateway to four hidden banks of thirty-two 16-bit registers each: a command register at address 20, a read-result register at address 21 and a staged write-value register at address 23. Every other direct address is plain storage.

The hidden banks stay locked until the command register receives an exact four-write handshake. Once unlocked, a single command word names the direction, the bank and the register index. A write command commits the staged value into the bank. A read command copies the bank register into the read-result register. Either command locks the banks again, and so does a write of zero to the command register. Bank 0 is meant for analog/DSP tuning, bank 1 for wake-on-LAN status, bank 2 for self-test and fractional PLL setup (indices 0x1c and 0x1d hold the two fractional divider words), and bank 3 is spare. All four banks behave the same way.

Top module: `bank_gate_regs`

## Requirements
- R1: After reset every register reads zero and the banks are locked. The banks unlock only after four consecutive writes to address 20 with the values 0x0000, 0x0400, 0x0000 and 0x0400.
- R2: A command word written to address 20 while the banks are locked changes no bank register and does not change the read-result register.
- R3: An indirect write commits the value held at address 23 into bank `[12:11]` at index `[4:0]`. It is triggered by a command word with bit 14 (write) and bit 10 (test mode) set and bit 15 clear.
- R4: An indirect read uses a command word with bit 15 (read) and bit 10 set and bit 14 clear. It loads bank `[12:11]` at index `[9:5]` into the read-result register at address 21 on the clock edge that accepts the command.
- R5: Executing a command locks the banks again, so a second command needs a new handshake.
- R6: Writing 0x0000 to address 20 while unlocked locks the banks.
- R7: A write to address 20 that does not match the next handshake step restarts the handshake. A zero that breaks the sequence counts as its first step.
- R8: A command word with both bits 15 and 14 set, or with bit 10 clear, is ignored.
- R9: The read-result register holds its value until the next executed read command. Bus writes to address 21 have no effect.
- R10: A read strobe at any address returns that register on the read data port one clock later, and the port holds that value until the next strobe. Addresses 20 and 23 return the last value written to them.
- R11: Every direct address other than 20, 21 and 23 is a plain read/write 16-bit register.
- R12: The four banks are independent: the same index in different banks holds different values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Direct register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_re |

## Verification
Suppose the handshake tracker stops one step early or fails to lock again after a command. Then a command issued without a fresh handshake is executed, and the bank contents it writes show up at address 21 on the very next indirect read. A wrong bank or index decode puts data into a neighbouring slot, which shows on the first readback of either slot. A read-result register that follows the bank contents instead of holding its value shows as a changed value at address 21 after a later indirect write.

// File: rtl/bga_pkg.sv
package bga_pkg;
    localparam int DW      = 16;
    localparam int AW      = 5;
    localparam int BANK_W  = 2;
    localparam int IDX_W   = 5;

    localparam logic [AW-1:0] ADDR_CMD  = 5'd20;
    localparam logic [AW-1:0] ADDR_RRES = 5'd21;
    localparam logic [AW-1:0] ADDR_WVAL = 5'd23;

    localparam int BIT_RD   = 15;
    localparam int BIT_WR   = 14;
    localparam int BANK_LO  = 11;
    localparam int BIT_TM   = 10;
    localparam int RIDX_LO  = 5;
    localparam int WIDX_LO  = 0;

    localparam logic [DW-1:0] TM_ONLY = 16'h0400;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic              tm;
        logic [IDX_W-1:0]  ridx;
        logic [IDX_W-1:0]  widx;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DW-1:0] w);
        cmd_t c;
        c.rd   = w[BIT_RD];
        c.wr   = w[BIT_WR];
        c.bank = w[BANK_LO +: BANK_W];
        c.tm   = w[BIT_TM];
        c.ridx = w[RIDX_LO +: IDX_W];
        c.widx = w[WIDX_LO +: IDX_W];
        return c;
    endfunction
endpackage

// File: rtl/bga_unlock.sv
module bga_unlock
    import bga_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          cmd_fire,
    output logic          open
);
    typedef struct packed {
        logic       open;
        logic [1:0] stage;
    } ul_t;

    ul_t q, d;
    logic [DW-1:0] expect_w;
    logic          is_zero;

    always_comb begin
        d        = q;
        is_zero  = (cmd_wdata == '0);
        expect_w = q.stage[0] ? TM_ONLY : '0;
        if (cmd_we) begin
            if (q.open) begin
                if (cmd_fire || is_zero) d.open = 1'b0;
                d.stage = is_zero ? 2'd1 : 2'd0;
            end else if (cmd_wdata == expect_w) begin
                if (q.stage == 2'd3) begin
                    d.open  = 1'b1;
                    d.stage = 2'd0;
                end else begin
                    d.stage = q.stage + 2'd1;
                end
            end else begin
                d.stage = is_zero ? 2'd1 : 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign open = q.open;
endmodule

// File: rtl/bga_bank_store.sv
module bga_bank_store #(
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 32,
    parameter int WIDTH     = 16,
    localparam int BSEL_W   = $clog2(NUM_BANKS),
    localparam int ISEL_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BSEL_W-1:0] wbank,
    input  logic [ISEL_W-1:0] widx,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [BSEL_W-1:0] rbank,
    input  logic [ISEL_W-1:0] ridx,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] bank_out [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WIDTH-1:0] mem_q [DEPTH];
        logic             hit;
        assign hit = we && (wbank == BSEL_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (hit) begin
                mem_q[widx] <= wdata;
            end
        end

        assign bank_out[b] = mem_q[ridx];
    end

    assign rdata = bank_out[rbank];
endmodule

// File: rtl/bga_direct_array.sv
module bga_direct_array #(
    parameter int WIDTH = 16,
    parameter int ABITS = 5,
    localparam int DEPTH = 1 << ABITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ABITS-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [ABITS-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/bank_gate_regs.sv
module bank_gate_regs
    import bga_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_we,
    input  logic          reg_re,
    output logic [DW-1:0] reg_rdata
);
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int BANK_DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DW-1:0] cmd;
        logic [DW-1:0] wval;
        logic [DW-1:0] rres;
        logic [DW-1:0] rdata;
    } st_t;

    st_t q, d;
    cmd_t          cmd;
    logic          cmd_we, cmd_fire, bank_we, arr_we, access_open;
    logic [DW-1:0] bank_rdata, arr_rdata, read_hold;

    always_comb begin
        cmd      = decode_cmd(reg_wdata);
        cmd_we   = reg_we && (reg_addr == ADDR_CMD);
        cmd_fire = cmd_we && access_open && cmd.tm && (cmd.rd ^ cmd.wr);
        bank_we  = cmd_fire && cmd.wr;
        arr_we   = reg_we && (reg_addr != ADDR_CMD) && (reg_addr != ADDR_RRES)
                   && (reg_addr != ADDR_WVAL);
    end

    always_comb begin
        d = q;
        if (cmd_we) d.cmd = reg_wdata;
        if (reg_we && reg_addr == ADDR_WVAL) d.wval = reg_wdata;
        if (cmd_fire && cmd.rd) d.rres = bank_rdata;
        if (reg_re) begin
            case (reg_addr)
                ADDR_CMD:  d.rdata = q.cmd;
                ADDR_RRES: d.rdata = q.rres;
                ADDR_WVAL: d.rdata = q.wval;
                default:   d.rdata = arr_rdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    bga_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (reg_wdata),
        .cmd_fire  (cmd_fire),
        .open      (access_open)
    );

    bga_bank_store #(
        .NUM_BANKS (NUM_BANKS),
        .DEPTH     (BANK_DEPTH),
        .WIDTH     (DW)
    ) u_banks (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .wbank (cmd.bank),
        .widx  (cmd.widx),
        .wdata (q.wval),
        .rbank (cmd.bank),
        .ridx  (cmd.ridx),
        .rdata (bank_rdata)
    );

    bga_direct_array #(
        .WIDTH (DW),
        .ABITS (AW)
    ) u_direct (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (reg_addr),
        .wdata (reg_wdata),
        .raddr (reg_addr),
        .rdata (arr_rdata)
    );

    assign read_hold = q.rres;
    assign reg_rdata = q.rdata;
endmodule

// File: rtl/bga_chk.sv
module bga_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        reg_we,
    input logic        reg_re,
    input logic [15:0] reg_rdata,
    input logic        access_open,
    input logic [15:0] read_hold
);
    logic cmd_wr;
    assign cmd_wr = reg_we && (reg_addr == 5'd20);

    // R1
    unlock_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_open) |-> $past(cmd_wr && reg_wdata == 16'h0400));

    // R2
    locked_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !access_open) |=> $stable(read_hold));

    // R5
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && access_open && reg_wdata[10] && (reg_wdata[15] ^ reg_wdata[14]))
        |=> !access_open);

    // R6
    zero_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata == 16'h0000) |=> !access_open);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(read_hold));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));
endmodule

bind bank_gate_regs bga_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .reg_re      (reg_re),
    .reg_rdata   (reg_rdata),
    .access_open (access_open),
    .read_hold   (read_hold)
);

// File: tb/bank_gate_regs_bench.sv
module bank_gate_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    bank_gate_regs u_bank_gate_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] wcmd(input logic [1:0] b, input logic [4:0] i);
        return {1'b0, 1'b1, 1'b0, b, 1'b1, 5'd0, i};
    endfunction

    function automatic logic [15:0] rcmd(input logic [1:0] b, input logic [4:0] i);
        return {1'b1, 1'b0, 1'b0, b, 1'b1, i, 5'd0};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [4:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic unlock();
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
    endtask

    task automatic ind_write(input logic [1:0] b, input logic [4:0] i, input logic [15:0] v);
        unlock();
        wr(5'd23, v);
        wr(5'd20, wcmd(b, i));
        wr(5'd20, 16'h0000);
    endtask

    task automatic ind_read(input logic [1:0] b, input logic [4:0] i);
        unlock();
        wr(5'd20, rcmd(b, i));
        wr(5'd20, 16'h0000);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor: pops one expected item per read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (reg_re) begin
                @(negedge clk);
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected read: actual %h expected none", reg_rdata);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (reg_rdata !== e) begin
                        fails++;
                        $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_exp(5'd21, 16'h0000, "R1 read-result after reset");
        rd_exp(5'd9,  16'h0000, "R1 direct reg after reset");
        rd_exp(5'd20, 16'h0000, "R1 command reg after reset");

        // R2 command while locked
        wr(5'd23, 16'hBEEF);
        wr(5'd20, wcmd(2'd2, 5'h1c));
        ind_read(2'd2, 5'h1c);
        rd_exp(5'd21, 16'h0000, "R2 locked write ignored");

        // R3 / R4 self-test bank setup and readback
        ind_write(2'd2, 5'h1c, 16'h0005);
        ind_write(2'd2, 5'h1d, 16'h029a);
        ind_read(2'd2, 5'h1d);
        rd_exp(5'd21, 16'h029a, "R3 indirect write");
        ind_read(2'd2, 5'h1c);
        rd_exp(5'd21, 16'h0005, "R4 indirect read");

        // R5 second command without fresh handshake
        unlock();
        wr(5'd23, 16'h1111);
        wr(5'd20, wcmd(2'd0, 5'd3));
        wr(5'd20, wcmd(2'd0, 5'd4));
        ind_read(2'd0, 5'd4);
        rd_exp(5'd21, 16'h0000, "R5 relocked after command");
        ind_read(2'd0, 5'd3);
        rd_exp(5'd21, 16'h1111, "R5 first command executed");

        // R6 zero locks
        unlock();
        wr(5'd20, 16'h0000);
        wr(5'd23, 16'h2222);
        wr(5'd20, wcmd(2'd1, 5'd7));
        ind_read(2'd1, 5'd7);
        rd_exp(5'd21, 16'h0000, "R6 zero write locks");

        // R7 broken sequence, then zero-restart sequence
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
        wr(5'd20, 16'h0005); wr(5'd20, 16'h0400);
        wr(5'd23, 16'h3333);
        wr(5'd20, wcmd(2'd1, 5'd8));
        ind_read(2'd1, 5'd8);
        rd_exp(5'd21, 16'h0000, "R7 broken handshake");
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
        wr(5'd20, 16'h0000); wr(5'd20, 16'h0400);
        wr(5'd23, 16'h4444);
        wr(5'd20, wcmd(2'd1, 5'd9));
        wr(5'd20, 16'h0000);
        ind_read(2'd1, 5'd9);
        rd_exp(5'd21, 16'h4444, "R7 zero restarts handshake");

        // R8 both flags, missing test-mode bit
        unlock();
        wr(5'd23, 16'h5555);
        wr(5'd20, wcmd(2'd1, 5'd10) | 16'h8000);
        wr(5'd20, wcmd(2'd1, 5'd10) & ~16'h0400);
        wr(5'd20, 16'h0000);
        ind_read(2'd1, 5'd10);
        rd_exp(5'd21, 16'h0000, "R8 malformed commands ignored");

        // R9 read-result holds; bus write to 21 ignored
        ind_read(2'd2, 5'h1d);
        ind_write(2'd2, 5'h1d, 16'h7777);
        rd_exp(5'd21, 16'h029a, "R9 holds across bank write");
        wr(5'd21, 16'hFFFF);
        rd_exp(5'd21, 16'h029a, "R9 bus write to read-result");

        // R10 direct readback of command and write-value registers
        wr(5'd20, 16'h1234);
        rd_exp(5'd20, 16'h1234, "R10 command reg readback");
        wr(5'd23, 16'hABCD);
        rd_exp(5'd23, 16'hABCD, "R10 write-value readback");

        // R11 plain registers
        wr(5'd5, 16'h0F0F);
        wr(5'd31, 16'hF00D);
        wr(5'd0, 16'h0001);
        rd_exp(5'd5, 16'h0F0F, "R11 direct reg 5");
        rd_exp(5'd31, 16'hF00D, "R11 direct reg 31");
        rd_exp(5'd0, 16'h0001, "R11 direct reg 0");

        // R12 bank independence at one index
        ind_write(2'd0, 5'h1c, 16'hA0A0);
        ind_write(2'd3, 5'h1c, 16'hB3B3);
        ind_read(2'd0, 5'h1c);
        rd_exp(5'd21, 16'hA0A0, "R12 bank 0");
        ind_read(2'd3, 5'h1c);
        rd_exp(5'd21, 16'hB3B3, "R12 bank 3");
        ind_read(2'd1, 5'h1c);
        rd_exp(5'd21, 16'h0000, "R12 bank 1");
        ind_read(2'd2, 5'h1c);
        rd_exp(5'd21, 16'h0005, "R12 bank 2");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule